// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a parallel-input voltage DAC. It takes update requests from logic in the chip over a valid/ready handshake. It then drives the converter's pins: a data bus, a low-byte select, a high-byte select, a write strobe, a load strobe, a clear strobe and a level that chooses between midscale and zero-scale clear. All strobes are active low and rest high.

A request is sent either as one wide write, with both selects low, or as two byte writes on the lower data lines, one for each select. The converter's output register is updated either by a load pulse issued right after the write, or by a later load request, so that several converters can be updated together. Each minimum width and setup time is given in nanoseconds and turned into clock cycles by rounding up. After reset the block waits out a start-up delay before it touches any pin.

Top module: `dac_wr_seq`

## Requirements
- R1: Out of reset every strobe is high, `req_ready_o` is low and `dac_mid_o` equals `MID_RST`. Strobes stay high and ready stays low for exactly `STARTUP_CYC` = ceil(STARTUP_NS·1000/CLK_PS) clock edges after reset release (2500 at defaults). Ready rises after the last of those edges, even if a request is already waiting.
- R2: A request accepted with `wide_i`=1 produces one write pulse. `dac_wr_n_o` and both selects go low at the accepting edge and stay low for exactly `STROBE_CYC` cycles, where `STROBE_CYC` = max of the rounded-up pulse width and the rounded-up data setup (10 at defaults). During the pulse `dac_d_o` carries the full word.
- R3: A request with `wide_i`=0 produces two write pulses of `STROBE_CYC` cycles, separated by one cycle with all strobes high. The first pulse uses `dac_cs_lo_n_o` and carries bits 7..0 on `dac_d_o[7:0]`. The second uses `dac_cs_hi_n_o` and carries bits 15..8 on `dac_d_o[7:0]`. `dac_d_o[15:8]` is 0 in both. `BYTE_HI_FIRST`=1 swaps the order.
- R4: `dac_d_o` holds one value over the whole write-low interval. A select is low only while the write strobe is low.
- R5: With `auto_load_i`=1 at acceptance, one all-high cycle follows the last write pulse, and then `dac_load_n_o` is low for `STROBE_CYC` cycles.
- R6: With `auto_load_i`=0 no load follows the write. A one-cycle `load_req_i` pulse while idle drives `dac_load_n_o` low from the next edge for `STROBE_CYC` cycles, with write, selects and clear held high.
- R7: A one-cycle `clr_req_i` pulse drives `dac_clr_n_o` low for `STROBE_CYC` cycles with every other strobe high. `dac_mid_o` takes the `mid_sel_i` level at the edge where the clear starts, and it holds that level afterwards.
- R8: `req_ready_o` is low from the accepting edge until the cycle after the last strobe of the operation is released. It is never high while any strobe is low.
- R9: When several requests are waiting in idle, they are served in this order: clear, then data, then load. `req_ready_o` is low while a clear is waiting. Clear or load requests that arrive during an operation are held and served once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Update request valid |
| req_ready_o | output | 1 | Sequencer can accept a data request |
| req_data_i | input | 16 | Word to send |
| wide_i | input | 1 | 1: one wide write, 0: two byte writes |
| auto_load_i | input | 1 | 1: load pulse follows the write |
| load_req_i | input | 1 | Deferred load request pulse |
| clr_req_i | input | 1 | Clear request pulse |
| mid_sel_i | input | 1 | Clear level select for the next clear |
| dac_d_o | output | 16 | Converter data lines |
| dac_cs_lo_n_o | output | 1 | Low-byte select, active low |
| dac_cs_hi_n_o | output | 1 | High-byte select, active low |
| dac_wr_n_o | output | 1 | Write strobe, active low |
| dac_load_n_o | output | 1 | Load strobe, active low |
| dac_clr_n_o | output | 1 | Clear strobe, active low |
| dac_mid_o | output | 1 | Midscale (1) or zero-scale (0) clear level |

## Verification
Every pin is registered from the next state, so each pulse starts at the very edge that accepts its request: that is the accept edge for data, and the request edge for a load or clear started from idle. The bench therefore samples on the falling edge and checks cycle 0 as the first cycle of the pulse. After that it walks a precomputed schedule of segments: `STROBE_CYC` pulse cycles, one all-high gap cycle between pulses, and one idle cycle in which ready must be high. It compares strobes, ready and data in every cycle of every segment. For the start-up delay it checks ready in each of the 2500 cycles after reset release, with a request already pending. For held requests it counts the extra idle cycle in which ready stays low before the clear starts.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_A, ST_WR_B, ST_GAP, ST_LOAD, ST_CLEAR
  } st_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dac_seq_startup.sv
module dac_seq_startup #(
  parameter int CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int SW = $clog2(CYC + 1);
  logic [SW-1:0] cnt_q;

  assign done_o = (cnt_q == SW'(CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt_q;

  assign expire_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (start_i)   cnt_q <= CW'(CYC - 1);
    else if (!expire_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
  import dac_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          started_i,
  input  logic          expire_i,
  input  logic          req_valid_i,
  input  logic [DW-1:0] req_data_i,
  input  logic          wide_i,
  input  logic          auto_i,
  input  logic          load_req_i,
  input  logic          clr_req_i,
  output logic          ready_o,
  output logic          start_o,
  output st_e           st_q_o,
  output st_e           st_d_o,
  output logic [DW-1:0] word_nx_o,
  output logic          wide_nx_o
);
  st_e           st_q, st_d, after_q, after_d;
  logic [DW-1:0] word_q;
  logic          wide_q, auto_q, pend_ld_q, pend_clr_q;
  logic          clr_pend, ld_pend, accept, auto_nx;

  assign clr_pend = pend_clr_q | clr_req_i;
  assign ld_pend  = pend_ld_q | load_req_i;
  assign ready_o  = (st_q == ST_IDLE) && started_i && !clr_pend;
  assign accept   = ready_o && req_valid_i;

  assign word_nx_o = accept ? req_data_i : word_q;
  assign wide_nx_o = accept ? wide_i : wide_q;
  assign auto_nx   = accept ? auto_i : auto_q;

  always_comb begin
    st_d    = st_q;
    after_d = after_q;
    unique case (st_q)
      ST_IDLE: if (started_i) begin
        if (clr_pend)         st_d = ST_CLEAR;
        else if (req_valid_i) st_d = ST_WR_A;
        else if (ld_pend)     st_d = ST_LOAD;
      end
      ST_WR_A: if (expire_i) begin
        if (!wide_q)     begin st_d = ST_GAP; after_d = ST_WR_B; end
        else if (auto_q) begin st_d = ST_GAP; after_d = ST_LOAD; end
        else             st_d = ST_IDLE;
      end
      ST_WR_B: if (expire_i) begin
        if (auto_q) begin st_d = ST_GAP; after_d = ST_LOAD; end
        else        st_d = ST_IDLE;
      end
      ST_GAP:   st_d = after_q;
      ST_LOAD,
      ST_CLEAR: if (expire_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign start_o = (st_d != st_q);
  assign st_q_o  = st_q;
  assign st_d_o  = st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      after_q    <= ST_IDLE;
      word_q     <= '0;
      wide_q     <= 1'b0;
      auto_q     <= 1'b0;
      pend_ld_q  <= 1'b0;
      pend_clr_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      after_q    <= after_d;
      word_q     <= word_nx_o;
      wide_q     <= wide_nx_o;
      auto_q     <= auto_nx;
      // pending flags drop only when served from idle
      pend_clr_q <= clr_pend && !(st_q == ST_IDLE && st_d == ST_CLEAR);
      pend_ld_q  <= ld_pend && !(st_q == ST_IDLE && st_d == ST_LOAD);
    end
  end
endmodule

// File: rtl/dac_seq_pins.sv
module dac_seq_pins
  import dac_seq_pkg::*;
#(
  parameter int DW            = 16,
  parameter bit BYTE_HI_FIRST = 1'b0,
  parameter bit MID_RST       = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  st_e           st_q_i,
  input  st_e           st_d_i,
  input  logic [DW-1:0] word_i,
  input  logic          wide_i,
  input  logic          mid_sel_i,
  output logic [DW-1:0] d_o,
  output logic          cs_lo_n_o,
  output logic          cs_hi_n_o,
  output logic          wr_n_o,
  output logic          load_n_o,
  output logic          clr_n_o,
  output logic          mid_o
);
  localparam int BW = DW / 2;

  logic [BW-1:0] byte_a, byte_b;
  logic          a_is_hi;
  logic [DW-1:0] d_d, d_q;
  logic          cs_lo_d, cs_hi_d, wr_d, ld_d, clr_d, mid_d;
  logic          cs_lo_q, cs_hi_q, wr_q, ld_q, clr_q, mid_q;

  generate
    if (BYTE_HI_FIRST) begin : g_hi_first
      assign byte_a  = word_i[DW-1:BW];
      assign byte_b  = word_i[BW-1:0];
      assign a_is_hi = 1'b1;
    end else begin : g_lo_first
      assign byte_a  = word_i[BW-1:0];
      assign byte_b  = word_i[DW-1:BW];
      assign a_is_hi = 1'b0;
    end
  endgenerate

  always_comb begin
    d_d     = d_q;
    mid_d   = mid_q;
    cs_lo_d = 1'b1;
    cs_hi_d = 1'b1;
    wr_d    = 1'b1;
    ld_d    = 1'b1;
    clr_d   = 1'b1;
    unique case (st_d_i)
      ST_WR_A: begin
        wr_d = 1'b0;
        if (wide_i) begin
          cs_lo_d = 1'b0;
          cs_hi_d = 1'b0;
          d_d     = word_i;
        end else begin
          cs_lo_d = a_is_hi;
          cs_hi_d = !a_is_hi;
          d_d     = {{(DW-BW){1'b0}}, byte_a};
        end
      end
      ST_WR_B: begin
        wr_d    = 1'b0;
        cs_lo_d = !a_is_hi;
        cs_hi_d = a_is_hi;
        d_d     = {{(DW-BW){1'b0}}, byte_b};
      end
      ST_LOAD:  ld_d = 1'b0;
      ST_CLEAR: begin
        clr_d = 1'b0;
        if (st_q_i != ST_CLEAR) mid_d = mid_sel_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q     <= '0;
      cs_lo_q <= 1'b1;
      cs_hi_q <= 1'b1;
      wr_q    <= 1'b1;
      ld_q    <= 1'b1;
      clr_q   <= 1'b1;
      mid_q   <= MID_RST;
    end else begin
      d_q     <= d_d;
      cs_lo_q <= cs_lo_d;
      cs_hi_q <= cs_hi_d;
      wr_q    <= wr_d;
      ld_q    <= ld_d;
      clr_q   <= clr_d;
      mid_q   <= mid_d;
    end
  end

  assign d_o       = d_q;
  assign cs_lo_n_o = cs_lo_q;
  assign cs_hi_n_o = cs_hi_q;
  assign wr_n_o    = wr_q;
  assign load_n_o  = ld_q;
  assign clr_n_o   = clr_q;
  assign mid_o     = mid_q;
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_seq_pkg::*;
#(
  parameter int DW            = 16,
  parameter int CLK_PS        = 4000,
  parameter int PULSE_NS      = 40,
  parameter int SETUP_NS      = 40,
  parameter int STARTUP_NS    = 10000,
  parameter bit BYTE_HI_FIRST = 1'b0,
  parameter bit MID_RST       = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [DW-1:0] req_data_i,
  input  logic          wide_i,
  input  logic          auto_load_i,
  input  logic          load_req_i,
  input  logic          clr_req_i,
  input  logic          mid_sel_i,
  output logic [DW-1:0] dac_d_o,
  output logic          dac_cs_lo_n_o,
  output logic          dac_cs_hi_n_o,
  output logic          dac_wr_n_o,
  output logic          dac_load_n_o,
  output logic          dac_clr_n_o,
  output logic          dac_mid_o
);
  localparam int PULSE_CYC   = ceil_div(PULSE_NS * 1000, CLK_PS);
  localparam int SETUP_CYC   = ceil_div(SETUP_NS * 1000, CLK_PS);
  localparam int STROBE_CYC  = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int STARTUP_CYC = ceil_div(STARTUP_NS * 1000, CLK_PS);

  logic          started, expire, start;
  st_e           st_q, st_d;
  logic [DW-1:0] word_nx;
  logic          wide_nx;

  dac_seq_startup #(.CYC(STARTUP_CYC)) u_startup (
    .clk_i, .rst_ni, .done_o(started)
  );

  dac_seq_timer #(.CYC(STROBE_CYC)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .expire_o(expire)
  );

  dac_seq_fsm #(.DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .started_i   (started),
    .expire_i    (expire),
    .req_valid_i,
    .req_data_i,
    .wide_i,
    .auto_i      (auto_load_i),
    .load_req_i,
    .clr_req_i,
    .ready_o     (req_ready_o),
    .start_o     (start),
    .st_q_o      (st_q),
    .st_d_o      (st_d),
    .word_nx_o   (word_nx),
    .wide_nx_o   (wide_nx)
  );

  dac_seq_pins #(
    .DW(DW), .BYTE_HI_FIRST(BYTE_HI_FIRST), .MID_RST(MID_RST)
  ) u_pins (
    .clk_i, .rst_ni,
    .st_q_i    (st_q),
    .st_d_i    (st_d),
    .word_i    (word_nx),
    .wide_i    (wide_nx),
    .mid_sel_i,
    .d_o       (dac_d_o),
    .cs_lo_n_o (dac_cs_lo_n_o),
    .cs_hi_n_o (dac_cs_hi_n_o),
    .wr_n_o    (dac_wr_n_o),
    .load_n_o  (dac_load_n_o),
    .clr_n_o   (dac_clr_n_o),
    .mid_o     (dac_mid_o)
  );
endmodule

// File: rtl/dac_wr_seq_chk.sv
module dac_wr_seq_chk #(
  parameter int DW          = 16,
  parameter int STROBE_CYC  = 10,
  parameter int STARTUP_CYC = 2500
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic [DW-1:0] dac_d_o,
  input logic          dac_cs_lo_n_o,
  input logic          dac_cs_hi_n_o,
  input logic          dac_wr_n_o,
  input logic          dac_load_n_o,
  input logic          dac_clr_n_o
);
  localparam int BW = DW / 2;

  logic [31:0] up_q;
  logic [15:0] run_q;
  logic        any_low;

  assign any_low = !(dac_cs_lo_n_o && dac_cs_hi_n_o && dac_wr_n_o &&
                     dac_load_n_o && dac_clr_n_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= '0;
      run_q <= '0;
    end else begin
      if (up_q < 32'(STARTUP_CYC)) up_q <= up_q + 1'b1;
      run_q <= dac_wr_n_o ? 16'd0 : run_q + 1'b1;
    end
  end

  // R1
  startup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q < 32'(STARTUP_CYC)) |-> (!any_low && !req_ready_o));

  // R2
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_wr_n_o && run_q != 16'd0) |-> (run_q == 16'(STROBE_CYC)));

  // R3
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_cs_lo_n_o != dac_cs_hi_n_o) |-> (dac_d_o[DW-1:BW] == '0));

  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_wr_n_o && !$past(dac_wr_n_o)) |-> $stable(dac_d_o));

  // R4
  sel_in_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_cs_lo_n_o || !dac_cs_hi_n_o) |-> !dac_wr_n_o);

  // R6
  load_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_n_o |-> (dac_wr_n_o && dac_cs_lo_n_o && dac_cs_hi_n_o && dac_clr_n_o));

  // R7
  clr_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_clr_n_o |-> (dac_wr_n_o && dac_cs_lo_n_o && dac_cs_hi_n_o && dac_load_n_o));

  // R8
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_low |-> !req_ready_o);
endmodule

bind dac_wr_seq dac_wr_seq_chk #(
  .DW(DW), .STROBE_CYC(STROBE_CYC), .STARTUP_CYC(STARTUP_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .dac_d_o       (dac_d_o),
  .dac_cs_lo_n_o (dac_cs_lo_n_o),
  .dac_cs_hi_n_o (dac_cs_hi_n_o),
  .dac_wr_n_o    (dac_wr_n_o),
  .dac_load_n_o  (dac_load_n_o),
  .dac_clr_n_o   (dac_clr_n_o)
);

// File: tb/sim_dac_wr_seq.sv
`timescale 1ns/1ps
module sim_dac_wr_seq;
  localparam int T = 10;      // 40 ns at 4 ns, rounded up
  localparam int S = 2500;    // 10 us at 4 ns

  localparam logic [4:0] P_IDLE = 5'b11111;  // {cs_lo,cs_hi,wr,load,clr}
  localparam logic [4:0] P_WIDE = 5'b00011;
  localparam logic [4:0] P_LO   = 5'b01011;
  localparam logic [4:0] P_HI   = 5'b10011;
  localparam logic [4:0] P_LD   = 5'b11101;
  localparam logic [4:0] P_CL   = 5'b11110;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid = 1'b0, wide = 1'b0, autol = 1'b0, ldreq = 1'b0, clrreq = 1'b0, midsel = 1'b0;
  logic [15:0] data = '0;
  logic ready, cs_lo_n, cs_hi_n, wr_n, ld_n, clr_n, mid;
  logic [15:0] d;
  int errors = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  dac_wr_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_ready_o(ready),
    .req_data_i(data), .wide_i(wide), .auto_load_i(autol), .load_req_i(ldreq),
    .clr_req_i(clrreq), .mid_sel_i(midsel), .dac_d_o(d), .dac_cs_lo_n_o(cs_lo_n),
    .dac_cs_hi_n_o(cs_hi_n), .dac_wr_n_o(wr_n), .dac_load_n_o(ld_n),
    .dac_clr_n_o(clr_n), .dac_mid_o(mid)
  );

  wire [4:0] pins = {cs_lo_n, cs_hi_n, wr_n, ld_n, clr_n};

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
      finish_run();
    end
  end

  // n cycles sampled at falling edges, one check for the whole segment
  task automatic seg(input string tag, input int n, input logic [4:0] p,
                     input logic [15:0] ed, input bit chk_d, input logic rdy);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!bad && (pins !== p || ready !== rdy || (chk_d && d !== ed))) begin
        bad = 1;
        $display("FAIL %s cycle %0d: pins=%b ready=%b d=%h expected pins=%b ready=%b d=%h",
                 tag, i, pins, ready, d, p, rdy, ed);
      end
    end
    checks++;
    if (bad) errors++;
  endtask

  task automatic chk1(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] w, input logic wd, input logic al);
    @(negedge clk);
    chk1("R8 ready before request", {15'b0, ready}, 16'd1);
    valid = 1; data = w; wide = wd; autol = al;
    @(posedge clk); #1 valid = 0;
    if (wd) seg("R2 wide write", T, P_WIDE, w, 1, 0);
    else begin
      seg("R3 low byte write", T, P_LO, {8'h00, w[7:0]}, 1, 0);
      seg("R3 byte gap", 1, P_IDLE, '0, 0, 0);
      seg("R3 high byte write", T, P_HI, {8'h00, w[15:8]}, 1, 0);
    end
    if (al) begin
      seg("R5 gap before load", 1, P_IDLE, '0, 0, 0);
      seg("R5 auto load", T, P_LD, '0, 0, 0);
    end
    seg("R8 ready after last strobe", 1, P_IDLE, '0, 0, 1);
    if (!al) begin
      seg("R6 no load while deferred", 2, P_IDLE, '0, 0, 1);
      @(negedge clk); ldreq = 1;
      @(posedge clk); #1 ldreq = 0;
      seg("R6 deferred load", T, P_LD, '0, 0, 0);
      seg("R6 idle after load", 1, P_IDLE, '0, 0, 1);
    end
  endtask

  task automatic do_clear(input logic ms);
    @(negedge clk); midsel = ms; clrreq = 1;
    @(posedge clk); #1 clrreq = 0;
    seg("R7 clear pulse", T, P_CL, '0, 0, 0);
    seg("R7 idle after clear", 1, P_IDLE, '0, 0, 1);
    chk1("R7 mid level", {15'b0, mid}, {15'b0, ms});
  endtask

  initial begin
    // R1 reset state and start-up hold-off with a request already waiting
    #5;
    chk1("R1 reset pins", {11'b0, pins}, {11'b0, P_IDLE});
    chk1("R1 reset ready/mid", {14'b0, ready, mid}, 16'd0);
    valid = 1; data = 16'h1234; wide = 1; autol = 1;
    @(negedge clk); rst_ni = 1;
    begin
      bit bad = 0;
      for (int k = 1; k <= S; k++) begin
        @(negedge clk);
        if (!bad && (pins !== P_IDLE || ready !== (k == S))) begin
          bad = 1;
          $display("FAIL R1 startup cycle %0d: pins=%b ready=%b expected pins=%b ready=%b",
                   k, pins, ready, P_IDLE, (k == S));
        end
      end
      checks++;
      if (bad) errors++;
    end
    @(posedge clk); #1 valid = 0;
    seg("R2 first wide write", T, P_WIDE, 16'h1234, 1, 0);
    seg("R5 gap", 1, P_IDLE, '0, 0, 0);
    seg("R5 load", T, P_LD, '0, 0, 0);
    seg("R8 idle", 1, P_IDLE, '0, 0, 1);

    // sweep words over all four mode combinations
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w;
      w = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'((i * 16'h3A57) ^ 16'hA5C3);
      for (int m = 0; m < 4; m++) do_write(w, m[0], m[1]);
    end

    // R7 both clear levels
    do_clear(1'b1);
    do_clear(1'b0);
    do_clear(1'b1);

    // R9 clear, data and load all waiting at once
    @(negedge clk);
    midsel = 0; clrreq = 1; ldreq = 1; valid = 1; data = 16'hC3E1; wide = 1; autol = 0;
    #1 chk1("R9 ready low with clear waiting", {15'b0, ready}, 16'd0);
    @(posedge clk); #1 clrreq = 0; ldreq = 0;
    seg("R9 clear first", T, P_CL, '0, 0, 0);
    seg("R9 ready for data", 1, P_IDLE, '0, 0, 1);
    @(posedge clk); #1 valid = 0;
    seg("R9 data second", T, P_WIDE, 16'hC3E1, 1, 0);
    seg("R9 idle before held load", 1, P_IDLE, '0, 0, 1);
    seg("R9 load last", T, P_LD, '0, 0, 0);
    seg("R9 idle", 1, P_IDLE, '0, 0, 1);
    chk1("R9 mid after clear", {15'b0, mid}, 16'd0);

    // R9 clear arriving during a byte write is held
    @(negedge clk); valid = 1; data = 16'h5A96; wide = 0; autol = 0;
    @(posedge clk); #1 valid = 0;
    seg("R3 byte write A", 3, P_LO, 16'h0096, 1, 0);
    midsel = 1; clrreq = 1;
    seg("R3 byte write B", 1, P_LO, 16'h0096, 1, 0);
    clrreq = 0;
    seg("R3 byte write C", T - 4, P_LO, 16'h0096, 1, 0);
    seg("R3 gap", 1, P_IDLE, '0, 0, 0);
    seg("R3 high byte", T, P_HI, 16'h005A, 1, 0);
    seg("R9 held clear blocks ready", 1, P_IDLE, '0, 0, 0);
    seg("R9 held clear", T, P_CL, '0, 0, 0);
    seg("R9 idle after held clear", 1, P_IDLE, '0, 0, 1);
    chk1("R7 mid after held clear", {15'b0, mid}, 16'd1);

    finish_run();
  end
endmodule